// File: doc/BRIEF.md
# Host-Polled Launch Mailbox with Read Retry

This block sits on the register port of a memory device that carries its own processing engine. That engine can never take control of the bus, so every exchange with the host goes through registers that the host reads and writes. To launch work, the host writes the launch register. The block sends a single-cycle launch pulse to the engine and marks the job as running.

The host then reads the status register. While the job is still running, the block does not complete that read. It raises a one-cycle retry to the memory controller, which issues the read again on its own. The host therefore only ever receives a completed read. When the engine reports completion with a done pulse, the block latches the engine's result word and sets a sticky completion flag. The next status read completes and returns both.

A launch write that arrives while a job is running is dropped, and it leaves an error flag that the host can see.

Top module: `hpoll_mailbox`

## Requirements
- R1: After a synchronous reset, `host_rvalid`, `host_retry` and `job_start` are low, and the running, completion and error flags are clear.
- R2: A write to address `START_ADDR` while no job is running makes `job_start` high for exactly one cycle, starting the cycle after the write. It also marks the job as running and clears the completion and error flags.
- R3: A read of address `STATUS_ADDR` while a job is running gives `host_retry` high for exactly one cycle, in the cycle after the read, with `host_rvalid` low.
- R4: A read of `STATUS_ADDR` while no job is running gives `host_rvalid` high in the next cycle. In that cycle, `host_rstat` bit 0 is the completion flag, bit 1 is the running flag and bit 2 is the error flag, and `host_rdata` is the last captured result (zero after reset).
- R5: A `job_done` pulse while a job is running captures `job_result`, clears the running flag and sets the completion flag. The completion flag stays set across any number of status reads until the next accepted launch.
- R6: A launch write while a job is running produces no `job_start` and leaves the running and completion flags unchanged. It sets the error flag.
- R7: A `job_done` pulse while no job is running changes neither the completion flag nor the captured result.
- R8: A read of any address other than `STATUS_ADDR` completes the next cycle with zero data and zero status. A write to any address other than `START_ADDR` has no effect.
- R9: Every read request gets exactly one of `host_rvalid` or `host_retry` in the following cycle, and a write request gets neither.
- R10: When `job_done` and a status read fall in the same cycle, the read is answered with retry, and the read after it completes with the completion flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host register access valid this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data (contents unused by the launch register) |
| host_rvalid | output | 1 | Read completed; data and status valid |
| host_retry | output | 1 | Read not completed; controller must reissue it |
| host_rdata | output | DATA_W | Read data (result word on a status read) |
| host_rstat | output | 3 | Status flags {error, running, done} |
| job_start | output | 1 | One-cycle launch pulse to the engine |
| job_done | input | 1 | One-cycle completion pulse from the engine |
| job_result | input | DATA_W | Result word, sampled with `job_done` |

## Verification
Jobs are launched with engine latencies of one to six polls, so the run shows how many retries each latency produces and confirms that the first completed read carries that job's own result. One job also receives a second launch in its middle, which shows a dropped launch and the error flag that follows, as distinct from the flag being cleared by the next accepted launch. Every address in the space is swept with both reads and writes to separate the two live registers from the inert ones. Completion pulses are driven while idle and also in the same cycle as a poll, which checks that the retry decision uses the state as it was before that cycle.

// File: rtl/hpoll_pkg.sv
package hpoll_pkg;
  localparam int STAT_W  = 3;
  localparam int ST_DONE = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_ERR  = 2;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_LAUNCH = 2'd1,
    ACC_POLL   = 2'd2,
    ACC_RD_ETC = 2'd3
  } acc_e;
endpackage

// File: rtl/hpoll_decode.sv
module hpoll_decode
  import hpoll_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int START_ADDR  = 0,
  parameter int STATUS_ADDR = 1
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              kind
);
  localparam logic [ADDR_W-1:0] LAUNCH_A = ADDR_W'(START_ADDR);
  localparam logic [ADDR_W-1:0] POLL_A   = ADDR_W'(STATUS_ADDR);

  always_comb begin
    kind = ACC_NONE;
    if (req) begin
      if (we) begin
        if (addr == LAUNCH_A) kind = ACC_LAUNCH;
      end else if (addr == POLL_A) begin
        kind = ACC_POLL;
      end else begin
        kind = ACC_RD_ETC;
      end
    end
  end
endmodule

// File: rtl/hpoll_job_ctrl.sv
module hpoll_job_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_wr,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_result,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] result,
  output logic              launch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
      launch <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (launch_wr) begin
        if (busy) begin
          err <= 1'b1;
        end else begin
          busy   <= 1'b1;
          done   <= 1'b0;
          err    <= 1'b0;
          launch <= 1'b1;
        end
      end
      if (eng_done && busy) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= eng_result;
      end
    end
  end

  assert_launch_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (launch_wr && !busy) |=> (launch && busy && !done && !err));
  assert_launch_single_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);
  assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_done && busy) |=> (done && !busy));
  assert_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (launch_wr && busy) |=> (err && !launch));
  assert_stray_done_R7: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !busy && !launch_wr) |=> ($stable(result) && $stable(done)));
endmodule

// File: rtl/hpoll_resp.sv
module hpoll_resp
  import hpoll_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              kind,
  input  logic              busy,
  input  logic              done,
  input  logic              err,
  input  logic [DATA_W-1:0] result,
  output logic              rvalid,
  output logic              retry,
  output logic [DATA_W-1:0] rdata,
  output logic [STAT_W-1:0] rstat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      retry  <= 1'b0;
      rdata  <= '0;
      rstat  <= '0;
    end else begin
      rvalid <= 1'b0;
      retry  <= 1'b0;
      rdata  <= '0;
      rstat  <= '0;
      case (kind)
        ACC_POLL: begin
          if (busy) begin
            retry <= 1'b1;
          end else begin
            rvalid         <= 1'b1;
            rdata          <= result;
            rstat[ST_DONE] <= done;
            rstat[ST_BUSY] <= busy;
            rstat[ST_ERR]  <= err;
          end
        end
        ACC_RD_ETC: rvalid <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_resp_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(rvalid && retry));
  assert_retry_no_data_R3: assert property (@(posedge clk) disable iff (rst)
    retry |-> (rdata == '0 && rstat == '0));
endmodule

// File: rtl/hpoll_mailbox.sv
module hpoll_mailbox
  import hpoll_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int START_ADDR  = 0,
  parameter int STATUS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rvalid,
  output logic              host_retry,
  output logic [DATA_W-1:0] host_rdata,
  output logic [STAT_W-1:0] host_rstat,
  output logic              job_start,
  input  logic              job_done,
  input  logic [DATA_W-1:0] job_result
);
  localparam logic [ADDR_W-1:0] POLL_A = ADDR_W'(STATUS_ADDR);

  acc_e              kind;
  logic              busy, done, err;
  logic [DATA_W-1:0] result;
  logic              wdata_unused;

  assign wdata_unused = ^host_wdata;

  hpoll_decode #(
    .ADDR_W(ADDR_W), .START_ADDR(START_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_decode (
    .req(host_req), .we(host_we), .addr(host_addr), .kind(kind)
  );

  hpoll_job_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .launch_wr(kind == ACC_LAUNCH),
    .eng_done(job_done), .eng_result(job_result),
    .busy(busy), .done(done), .err(err), .result(result),
    .launch(job_start)
  );

  hpoll_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .kind(kind),
    .busy(busy), .done(done), .err(err), .result(result),
    .rvalid(host_rvalid), .retry(host_retry),
    .rdata(host_rdata), .rstat(host_rstat)
  );

  assert_read_answered_R9: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we) |=> (host_rvalid ^ host_retry));
  assert_write_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (!host_req || host_we) |=> (!host_rvalid && !host_retry));
  assert_poll_busy_retry_R3: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && host_addr == POLL_A && busy) |=> host_retry);
  assert_poll_idle_done_R4: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && host_addr == POLL_A && !busy && done)
      |=> (host_rvalid && host_rstat[ST_DONE]));
endmodule

// File: tb/hpoll_mailbox_test.sv
module hpoll_mailbox_test;
  import hpoll_pkg::*;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int SA = 0;
  localparam int PA = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_rvalid, host_retry, job_start;
  logic [DW-1:0] host_rdata;
  logic [2:0]    host_rstat;
  logic          job_done = 1'b0;
  logic [DW-1:0] job_result = '0;

  int checks = 0, fails = 0, starts = 0, cycles = 0;
  logic          r_valid, r_retry;
  logic [DW-1:0] r_data;
  logic [2:0]    r_stat;

  always #2 clk = ~clk;

  hpoll_mailbox #(.ADDR_W(AW), .DATA_W(DW), .START_ADDR(SA), .STATUS_ADDR(PA)) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_retry(host_retry),
    .host_rdata(host_rdata), .host_rstat(host_rstat),
    .job_start(job_start), .job_done(job_done), .job_result(job_result)
  );

  always @(negedge clk) begin
    if (job_start) starts++;
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL R9 watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    check("R9 write gives no response", {host_rvalid, host_retry}, 0);
  endtask

  task automatic hread(input logic [AW-1:0] a, input logic with_done, input logic [DW-1:0] res);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    job_done = with_done; job_result = res;
    @(negedge clk);
    r_valid = host_rvalid; r_retry = host_retry; r_data = host_rdata; r_stat = host_rstat;
    host_req = 1'b0; job_done = 1'b0;
    check("R9 exactly one response", r_valid ^ r_retry, 1);
  endtask

  task automatic pulse_done(input logic [DW-1:0] res);
    @(negedge clk);
    job_done = 1'b1; job_result = res;
    @(negedge clk);
    job_done = 1'b0;
  endtask

  initial begin
    int s0;
    logic [DW-1:0] last_res;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 outputs after reset", {host_rvalid, host_retry, job_start}, 0);
    hread(PA, 0, 0);
    check("R1 flags clear", r_stat, 0);
    // R4 idle poll
    check("R4 idle poll completes", r_valid, 1);
    check("R4 idle result zero", r_data, 0);
    // R7 stray done
    pulse_done(32'hDEAD_BEEF);
    hread(PA, 0, 0);
    check("R7 stray done no flag", r_stat, 0);
    check("R7 stray done no capture", r_data, 0);
    // R8 sweep of all addresses
    for (int a = 0; a < (1 << AW); a++) begin
      if (a == SA || a == PA) continue;
      s0 = starts;
      hwrite(AW'(a), 32'h5A5A_0000 + a);
      hread(AW'(a), 0, 0);
      check("R8 other read completes", r_valid, 1);
      check("R8 other read zero data", r_data, 0);
      check("R8 other read zero status", r_stat, 0);
      hread(PA, 0, 0);
      check("R8 other write no effect", {r_valid, r_stat}, 4'b1000);
      check("R8 other write no launch", starts, s0);
    end
    // jobs with latency 1..6 polls
    last_res = 0;
    for (int j = 1; j <= 6; j++) begin
      logic [DW-1:0] exp_res;
      exp_res = j * 32'h0102_0304 + 32'h11;
      s0 = starts;
      hwrite(SA, j);
      for (int p = 0; p < j; p++) begin
        hread(PA, 0, 0);
        check("R3 busy poll retries", {r_retry, r_valid}, 2'b10);
        check("R3 retry carries no data", r_data, 0);
        if (p == 0) check("R2 one launch pulse", starts, s0 + 1);
        if (j == 3 && p == 1) begin
          hwrite(SA, 99);
          hread(PA, 0, 0);
          check("R6 rejected launch still busy", r_retry, 1);
          check("R6 rejected launch no pulse", starts, s0 + 1);
        end
      end
      pulse_done(exp_res);
      for (int k = 0; k < 2; k++) begin
        hread(PA, 0, 0);
        check("R5 completed poll valid", r_valid, 1);
        check("R5 result word", r_data, exp_res);
        check((j == 3) ? "R6 error flag set" : "R2 error cleared by launch",
              r_stat, (j == 3) ? 3'b101 : 3'b001);
      end
      last_res = exp_res;
    end
    // R2 done cleared by new launch, R10 same-cycle done and poll
    hwrite(SA, 0);
    hread(PA, 1, 32'hCAFE_0010);
    check("R10 same-cycle poll retries", r_retry, 1);
    hread(PA, 0, 0);
    check("R10 next poll completes", {r_valid, r_stat}, 4'b1001);
    check("R10 result captured", r_data, 32'hCAFE_0010);
    // R7 stray done after completion keeps result
    pulse_done(32'h1234_5678);
    hread(PA, 0, 0);
    check("R7 stray done keeps result", r_data, 32'hCAFE_0010);
    // R1 reset mid-job
    hwrite(SA, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    hread(PA, 0, 0);
    check("R1 reset clears job", {r_valid, r_stat, r_data}, {1'b1, 3'b000, 32'h0});
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule